// File: doc/BRIEF.md
# Touch Panel Driver and Power Controller

This block sits between the serial-control sequencer of a touch-screen converter and the analog front end. It takes the control fields the sequencer has already latched: a 3-bit measurement channel, a reference-mode bit and a 2-bit power code. From them it produces the enables for the four panel drivers (X+, X-, Y+, Y-), the select for the converter input mux and the reference-source select.

The sequencer reports two phase strobes, acquire and convert, and a single-cycle pulse when the final result bit has left the serial port. The block times the panel drivers against the two phases. It keeps a powered/asleep state that a new conversion wakes at once. Once the last result bit is out, it drops to sleep or stays up according to the power code. It also drives an active-low touch interrupt from a pen-detect input. That interrupt is qualified by the power state and held inactive while any panel driver is on.

Every output is registered, so each one follows its inputs by exactly one clock.

Top module: `touch_drive_ctrl`

## Requirements
- R1: After reset all four driver enables are 0, mux_sel is 0 (ground), ref_diff is 0, pd_status is 1 and pen_irq_n is 1.
- R2: When the phase inputs enable the drivers, the enables follow the channel code. Code 001 turns on Y+ and Y-. Code 101 and code 110 turn on X+ and X-. Codes 011 and 100 turn on X- and Y+. Codes 010, 000 and 111 turn on no driver.
- R3: mux_sel uses the encoding 0=ground, 1=X+, 2=Y+, 3=Y-, 4=auxiliary. Channels 001, 011 and 110 give 1; channel 101 gives 2; channel 100 gives 3; channel 010 gives 4; the reserved codes 000 and 111 give 0. This holds in every phase.
- R4: ref_diff is 1 when ref_single is 0 (the reference is taken across the enabled drivers) and 0 when ref_single is 1 (the reference is the reference pin against ground).
- R5: During acquire (acq=1), the channel's drivers are on in both reference modes.
- R6: During convert only (conv=1, acq=0), the channel's drivers stay on in differential mode and are all off in single-ended mode.
- R7: With neither acq nor conv asserted, all drivers are off.
- R8: Any cycle with acq or conv asserted leaves pd_status at 0 on the next cycle, whatever the previous state.
- R9: A last_bit pulse with acq and conv low applies the power code. Codes 11 and 10 keep pd_status at 0. Codes 01 and 00 set pd_status to 1. Without a pulse or a phase strobe, pd_status holds its value.
- R10: pen_irq_n is 0 exactly when pen_det is 1, no driver is enabled, and the block is either powered or went to sleep under power code 00. Otherwise pen_irq_n is 1. After reset the sleep state counts as code 00.
- R11: pen_irq_n is 1 in every cycle in which any driver enable is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan | input | 3 | Latched measurement channel code |
| ref_single | input | 1 | 1 = single-ended reference, 0 = differential |
| pd_mode | input | 2 | Latched power code |
| acq | input | 1 | Acquire phase from sequencer |
| conv | input | 1 | Convert phase from sequencer |
| last_bit | input | 1 | Pulse: final result bit shifted out |
| pen_det | input | 1 | Panel touch sensed (active high) |
| xp_en | output | 1 | X+ driver enable |
| xn_en | output | 1 | X- driver enable |
| yp_en | output | 1 | Y+ driver enable |
| yn_en | output | 1 | Y- driver enable |
| mux_sel | output | 3 | Converter input select |
| ref_diff | output | 1 | 1 = reference across drivers |
| pd_status | output | 1 | 1 = powered down |
| pen_irq_n | output | 1 | Active-low touch interrupt |

## Verification
The bench sweeps every channel code against both reference modes and all four phase combinations. A design that swapped the pressure channels' mux inputs, or gave a reserved code a driver, would show up there. So would a design that released the switches during a differential conversion or kept them on during a single-ended one. Each power code is then exercised with and without a touch across a wake and a last-bit pulse. A design that treated the reserved code 10 as a sleep, or let the interrupt through under code 01, would report the wrong pd_status or pen_irq_n. A touch during acquisition checks that the interrupt stays high while a driver is on, and a touch on the auxiliary channel checks that it goes low when no driver is on.

// File: rtl/touch_drive_pkg.sv
package touch_drive_pkg;
    localparam int CHAN_W = 3;
    localparam int PD_W   = 2;
    localparam int MUX_W  = 3;

    typedef enum logic [MUX_W-1:0] {
        MUX_GND = 3'd0,
        MUX_XP  = 3'd1,
        MUX_YP  = 3'd2,
        MUX_YN  = 3'd3,
        MUX_AUX = 3'd4
    } mux_sel_e;

    typedef struct packed {
        logic xp;
        logic xn;
        logic yp;
        logic yn;
    } drv_t;

    typedef struct packed {
        drv_t     drv;
        mux_sel_e mux;
    } chan_cfg_t;

    localparam drv_t DRV_OFF = '{xp: 1'b0, xn: 1'b0, yp: 1'b0, yn: 1'b0};

    localparam logic [PD_W-1:0] PD_SLEEP_PEN = 2'b00;
    localparam logic [PD_W-1:0] PD_SLEEP_QUIET = 2'b01;

    function automatic chan_cfg_t decode_chan(input logic [CHAN_W-1:0] c);
        chan_cfg_t r;
        r.drv = DRV_OFF;
        r.mux = MUX_GND;
        case (c)
            3'b001: begin r.drv.yp = 1'b1; r.drv.yn = 1'b1; r.mux = MUX_XP; end
            3'b101: begin r.drv.xp = 1'b1; r.drv.xn = 1'b1; r.mux = MUX_YP; end
            3'b110: begin r.drv.xp = 1'b1; r.drv.xn = 1'b1; r.mux = MUX_XP; end
            3'b011: begin r.drv.xn = 1'b1; r.drv.yp = 1'b1; r.mux = MUX_XP; end
            3'b100: begin r.drv.xn = 1'b1; r.drv.yp = 1'b1; r.mux = MUX_YN; end
            3'b010: r.mux = MUX_AUX;
            default: ;
        endcase
        return r;
    endfunction

    // Codes 00 and 01 sleep between conversions; 11 and reserved 10 stay up.
    function automatic logic pd_sleeps(input logic [PD_W-1:0] m);
        return (m == PD_SLEEP_PEN) || (m == PD_SLEEP_QUIET);
    endfunction
endpackage

// File: rtl/tp_switch_timing.sv
module tp_switch_timing
    import touch_drive_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAN_W-1:0] chan,
    input  logic              ref_single,
    input  logic              acq,
    input  logic              conv,
    output drv_t              drv_next,
    output drv_t              drv_q,
    output mux_sel_e          mux_q,
    output logic              ref_diff_q
);
    chan_cfg_t cfg;
    logic      drive_window;

    always_comb begin
        cfg          = decode_chan(chan);
        // Differential mode keeps the panel biased through conversion.
        drive_window = acq | (conv & ~ref_single);
        drv_next     = drive_window ? cfg.drv : DRV_OFF;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            drv_q      <= DRV_OFF;
            mux_q      <= MUX_GND;
            ref_diff_q <= 1'b0;
        end else begin
            drv_q      <= drv_next;
            mux_q      <= cfg.mux;
            ref_diff_q <= ~ref_single;
        end
    end
endmodule

// File: rtl/tp_power_ctrl.sv
module tp_power_ctrl
    import touch_drive_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            acq,
    input  logic            conv,
    input  logic            last_bit,
    input  logic [PD_W-1:0] pd_mode,
    output logic            pen_ok_next,
    output logic            pd_status
);
    logic awake_q, awake_d;
    logic sleep_pen_q, sleep_pen_d;

    always_comb begin
        awake_d     = awake_q;
        sleep_pen_d = sleep_pen_q;
        if (acq || conv) begin
            awake_d = 1'b1;
        end else if (last_bit) begin
            awake_d     = ~pd_sleeps(pd_mode);
            sleep_pen_d = (pd_mode == PD_SLEEP_PEN);
        end
        pen_ok_next = awake_d | sleep_pen_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            awake_q     <= 1'b0;
            sleep_pen_q <= 1'b1;
        end else begin
            awake_q     <= awake_d;
            sleep_pen_q <= sleep_pen_d;
        end
    end

    assign pd_status = ~awake_q;
endmodule

// File: rtl/tp_pen_gate.sv
module tp_pen_gate (
    input  logic clk,
    input  logic rst,
    input  logic pen_det,
    input  logic pen_ok,
    input  logic drv_busy,
    output logic pen_irq_n
);
    always_ff @(posedge clk) begin
        if (rst) pen_irq_n <= 1'b1;
        else     pen_irq_n <= ~(pen_det & pen_ok & ~drv_busy);
    end
endmodule

// File: rtl/touch_drive_ctrl.sv
module touch_drive_ctrl
    import touch_drive_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CHAN_W-1:0] chan,
    input  logic              ref_single,
    input  logic [PD_W-1:0]   pd_mode,
    input  logic              acq,
    input  logic              conv,
    input  logic              last_bit,
    input  logic              pen_det,
    output logic              xp_en,
    output logic              xn_en,
    output logic              yp_en,
    output logic              yn_en,
    output logic [MUX_W-1:0]  mux_sel,
    output logic              ref_diff,
    output logic              pd_status,
    output logic              pen_irq_n
);
    drv_t     drv_next, drv_q;
    mux_sel_e mux_q;
    logic     pen_ok_next;

    tp_switch_timing u_sw (
        .clk(clk), .rst(rst), .chan(chan), .ref_single(ref_single),
        .acq(acq), .conv(conv), .drv_next(drv_next), .drv_q(drv_q),
        .mux_q(mux_q), .ref_diff_q(ref_diff)
    );

    tp_power_ctrl u_pwr (
        .clk(clk), .rst(rst), .acq(acq), .conv(conv), .last_bit(last_bit),
        .pd_mode(pd_mode), .pen_ok_next(pen_ok_next), .pd_status(pd_status)
    );

    tp_pen_gate u_pen (
        .clk(clk), .rst(rst), .pen_det(pen_det), .pen_ok(pen_ok_next),
        .drv_busy(|drv_next), .pen_irq_n(pen_irq_n)
    );

    assign xp_en   = drv_q.xp;
    assign xn_en   = drv_q.xn;
    assign yp_en   = drv_q.yp;
    assign yn_en   = drv_q.yn;
    assign mux_sel = mux_q;
endmodule

// File: rtl/touch_drive_checker.sv
module touch_drive_checker (
    input logic       clk,
    input logic       rst,
    input logic       ref_single,
    input logic [1:0] pd_mode,
    input logic       acq,
    input logic       conv,
    input logic       last_bit,
    input logic       xp_en,
    input logic       xn_en,
    input logic       yp_en,
    input logic       yn_en,
    input logic       pd_status,
    input logic       pen_irq_n
);
    logic any_en;
    assign any_en = xp_en | xn_en | yp_en | yn_en;

    assert_idle_off_R7: assert property (@(posedge clk) disable iff (rst)
        (!acq && !conv) |=> !any_en);

    assert_single_release_R6: assert property (@(posedge clk) disable iff (rst)
        (conv && !acq && ref_single) |=> !any_en);

    assert_pen_masked_R11: assert property (@(posedge clk) disable iff (rst)
        any_en |-> pen_irq_n);

    assert_wake_R8: assert property (@(posedge clk) disable iff (rst)
        (acq || conv) |=> !pd_status);

    assert_sleep_R9: assert property (@(posedge clk) disable iff (rst)
        (last_bit && !acq && !conv && !pd_mode[1]) |=> pd_status);

    assert_quiet_sleep_R10: assert property (@(posedge clk) disable iff (rst)
        (last_bit && !acq && !conv && pd_mode == 2'b01) |=> pen_irq_n);
endmodule

bind touch_drive_ctrl touch_drive_checker u_chk (
    .clk(clk), .rst(rst), .ref_single(ref_single), .pd_mode(pd_mode),
    .acq(acq), .conv(conv), .last_bit(last_bit),
    .xp_en(xp_en), .xn_en(xn_en), .yp_en(yp_en), .yn_en(yn_en),
    .pd_status(pd_status), .pen_irq_n(pen_irq_n)
);

// File: tb/touch_drive_ctrl_bench.sv
module touch_drive_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] chan;
    logic       ref_single;
    logic [1:0] pd_mode;
    logic       acq, conv, last_bit, pen_det;
    logic       xp_en, xn_en, yp_en, yn_en;
    logic [2:0] mux_sel;
    logic       ref_diff, pd_status, pen_irq_n;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #2.5 clk = ~clk;

    touch_drive_ctrl u_touch_drive_ctrl (
        .clk(clk), .rst(rst), .chan(chan), .ref_single(ref_single),
        .pd_mode(pd_mode), .acq(acq), .conv(conv), .last_bit(last_bit),
        .pen_det(pen_det), .xp_en(xp_en), .xn_en(xn_en), .yp_en(yp_en),
        .yn_en(yn_en), .mux_sel(mux_sel), .ref_diff(ref_diff),
        .pd_status(pd_status), .pen_irq_n(pen_irq_n)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // {xp,xn,yp,yn} per channel code, from R2
    function automatic logic [3:0] exp_drv(input logic [2:0] c);
        case (c)
            3'b001: return 4'b0011;
            3'b101, 3'b110: return 4'b1100;
            3'b011, 3'b100: return 4'b0110;
            default: return 4'b0000;
        endcase
    endfunction

    // mux code per channel, from R3
    function automatic int exp_mux(input logic [2:0] c);
        case (c)
            3'b001, 3'b011, 3'b110: return 1;
            3'b101: return 2;
            3'b100: return 3;
            3'b010: return 4;
            default: return 0;
        endcase
    endfunction

    task automatic step;
        @(negedge clk);
    endtask

    initial begin
        #100000;
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit awake;
        bit pen_sleep;
        rst = 1'b1; chan = 3'b000; ref_single = 1'b1; pd_mode = 2'b11;
        acq = 1'b0; conv = 1'b0; last_bit = 1'b0; pen_det = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state (no posedge has passed since rst dropped)
        check("R1", "drivers", {xp_en, xn_en, yp_en, yn_en}, 0);
        check("R1", "mux_sel", mux_sel, 0);
        check("R1", "ref_diff", ref_diff, 0);
        check("R1", "pd_status", pd_status, 1);
        check("R1", "pen_irq_n", pen_irq_n, 1);

        // R2-R7 sweep: channel x reference mode x phase
        for (int c = 0; c < 8; c++) begin
            for (int rs = 0; rs < 2; rs++) begin
                for (int ph = 0; ph < 4; ph++) begin
                    logic [3:0] e;
                    chan = 3'(c); ref_single = rs[0];
                    acq = ph[0]; conv = ph[1];
                    step();
                    if (acq) e = exp_drv(chan);          // R5
                    else if (conv && !ref_single) e = exp_drv(chan); // R6
                    else e = 4'b0000;                    // R6 single / R7 idle
                    check(acq ? "R5" : (conv ? "R6" : "R7"), "drivers",
                          {xp_en, xn_en, yp_en, yn_en}, e);
                    if (acq) check("R2", "decode", {xp_en, xn_en, yp_en, yn_en}, exp_drv(chan));
                    check("R3", "mux_sel", mux_sel, exp_mux(chan));
                    check("R4", "ref_diff", ref_diff, !ref_single);
                end
            end
        end
        acq = 1'b0; conv = 1'b0;
        step();

        // R8-R10 power codes with and without touch
        for (int pm = 0; pm < 4; pm++) begin
            for (int pd = 0; pd < 2; pd++) begin
                pd_mode = 2'(pm); pen_det = 1'b0;
                chan = 3'b001; ref_single = 1'b0; acq = 1'b1;
                pen_det = pd[0];
                step();
                check("R8", "pd_status after acq", pd_status, 0);
                check("R11", "pen masked while driving", pen_irq_n, 1);
                acq = 1'b0; last_bit = 1'b1;
                step();
                awake = (pm >= 2);
                pen_sleep = (pm == 0);
                check("R9", "pd_status after last bit", pd_status, awake ? 0 : 1);
                check("R10", "pen after last bit", pen_irq_n,
                      (pd[0] && (awake || pen_sleep)) ? 0 : 1);
                last_bit = 1'b0;
                step();
                check("R9", "pd_status hold", pd_status, awake ? 0 : 1);
                check("R10", "pen hold", pen_irq_n,
                      (pd[0] && (awake || pen_sleep)) ? 0 : 1);
                // wake straight from sleep with no delay
                conv = 1'b1; ref_single = 1'b1;
                step();
                check("R8", "wake on conv", pd_status, 0);
                check("R11", "pen single-ended conv", pen_irq_n, pd[0] ? 0 : 1);
                conv = 1'b0; pen_det = 1'b0;
                step();
            end
        end

        // R10: touch during aux acquisition (no drivers) while powered
        chan = 3'b010; acq = 1'b1; pen_det = 1'b1;
        step();
        check("R10", "pen aux acquire", pen_irq_n, 0);
        check("R11", "no drivers on aux", {xp_en, xn_en, yp_en, yn_en}, 0);
        chan = 3'b100;
        step();
        check("R11", "pen masked pressure", pen_irq_n, 1);
        check("R2", "pressure drivers", {xp_en, xn_en, yp_en, yn_en}, 4'b0110);
        acq = 1'b0; pen_det = 1'b0;
        step();

        done_flag = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule